// File: doc/BRIEF.md
# Interrupt Source Configuration Bank

This block holds the per-source configuration of a multiprocessor interrupt controller. Every interrupt source owns two 32-bit registers: a priority register, which carries the mask bit, the priority field, the vector number and a read-only activity flag, and a destination register, which holds two routing-mode bits and a bit mask selecting the target CPUs. Software reaches both registers over a plain single-cycle register bus. The arbitration and delivery logic reads the current values from the flat configuration outputs.

The bank filters every write. Writes to the priority register keep only the architected fields. The activity flag always follows the delivery logic and ignores the bus. Writes to the destination register drop any CPU bit above the configured CPU count. When a priority register is written, the bank sends a one-cycle reevaluate strobe for that source, so the pending logic can recompute its state. Sources set aside for inter-processor interrupts leave reset with an empty destination mask, so they raise nothing until software routes them.

Top module: `irq_src_cfg_bank`

## Requirements
- R1: After reset, every priority register reads 0x80800000, which means masked, priority 0 and vector 0.
- R2: After reset, every destination register reads 0x00000001 (CPU 0 only). The exception is the NUM_IPI sources starting at IPI_BASE, which read 0x00000000.
- R3: A write to a priority register stores the written value ANDed with 0x800F00FF. These bits are the mask at bit 31, the priority at bits 19:16 and the vector at bits 7:0. Every other bit except the activity flag reads 0.
- R4: Bit 30 of every priority register equals active_i for that source as sampled at the previous clock edge. Bus writes never change it.
- R5: A write to a destination register stores written bits 31:30 plus written bits NUM_CPU-1:0. All other bits read 0.
- R6: A register sits at byte offset 32*source + 16*sel. sel=0 selects the priority register and sel=1 selects the destination register. Read data appears on rdata_o in the cycle after the read request and holds until the next read.
- R7: A write whose offset bits 3:0 are not zero changes no register and raises no strobe.
- R8: A read whose offset bits 3:0 are not zero returns 0xFFFFFFFF.
- R9: An accepted priority-register write to source s raises reevaluate bit s alone, for exactly one cycle after the write edge. Destination writes raise no strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Bus access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | AW | Byte offset into the bank |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered |
| active_i | input | NUM_SRC | Activity flag per source from the delivery logic |
| prio_o | output | 32*NUM_SRC | Priority registers, source s at bits 32s+31:32s |
| dest_o | output | 32*NUM_SRC | Destination registers, source s at bits 32s+31:32s |
| reeval_o | output | NUM_SRC | One-cycle reevaluate strobe per source |

## Verification
The properties assume that active_i is low during reset, so the activity-tracking check may compare against the previous edge from the first cycle after release. They also assume that addr_i stays within the NUM_SRC slots, so every aligned access decodes to a real source. The bench holds active_i at zero through reset and only changes it at falling edges. It sweeps offsets strictly inside a small bank of eight sources and three CPUs, which keeps both assumptions true. Misaligned offsets are driven on purpose, and only through the low nibble.

// File: rtl/irq_cfg_pkg.sv
package irq_cfg_pkg;
  localparam int unsigned ACT_BIT    = 30;
  localparam logic [31:0] PRIO_WMASK = 32'h800F_00FF;
  localparam logic [31:0] PRIO_RST   = 32'h8080_0000;
  localparam logic [31:0] DEST_RST   = 32'h0000_0001;
  localparam logic [31:0] DEST_MODE  = 32'hC000_0000;

  typedef enum logic {SEL_PRIO = 1'b0, SEL_DEST = 1'b1} reg_sel_e;

  function automatic logic [31:0] dest_keep(int unsigned ncpu);
    return DEST_MODE | ((32'd1 << ncpu) - 32'd1);
  endfunction
endpackage

// File: rtl/irq_cfg_decode.sv
module irq_cfg_decode
  import irq_cfg_pkg::*;
#(
  parameter int unsigned NUM_SRC = 16,
  parameter int unsigned IW      = 4,
  parameter int unsigned AW      = 9
) (
  input  logic [AW-1:0] addr_i,
  output logic [IW-1:0] idx_o,
  output reg_sel_e      sel_o,
  output logic          hit_o
);
  always_comb begin
    idx_o = addr_i[AW-1:5];
    sel_o = addr_i[4] ? SEL_DEST : SEL_PRIO;
    hit_o = (addr_i[3:0] == 4'd0) && (int'(idx_o) < int'(NUM_SRC));
  end
endmodule

// File: rtl/irq_cfg_slot.sv
module irq_cfg_slot
  import irq_cfg_pkg::*;
#(
  parameter int unsigned NUM_CPU = 4,
  parameter bit          IS_IPI  = 1'b0
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_prio_i,
  input  logic        wr_dest_i,
  input  logic [31:0] wdata_i,
  input  logic        active_i,
  output logic [31:0] prio_o,
  output logic [31:0] dest_o,
  output logic        reeval_o
);
  localparam logic [31:0] DEST_KEEP = dest_keep(NUM_CPU);
  localparam logic [31:0] DEST_INIT = IS_IPI ? 32'h0 : DEST_RST;

  logic [31:0] prio_q, dest_q;
  logic        act_q, reeval_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prio_q   <= PRIO_RST;
      dest_q   <= DEST_INIT;
      act_q    <= 1'b0;
      reeval_q <= 1'b0;
    end else begin
      act_q    <= active_i;
      reeval_q <= wr_prio_i;
      if (wr_prio_i) prio_q <= wdata_i & PRIO_WMASK;
      if (wr_dest_i) dest_q <= wdata_i & DEST_KEEP;
    end
  end

  // activity flag is owned by delivery logic, overlaid on read
  always_comb begin
    prio_o          = prio_q;
    prio_o[ACT_BIT] = act_q;
  end

  assign dest_o   = dest_q;
  assign reeval_o = reeval_q;
endmodule

// File: rtl/irq_src_cfg_bank.sv
module irq_src_cfg_bank
  import irq_cfg_pkg::*;
#(
  parameter int unsigned NUM_SRC  = 16,
  parameter int unsigned NUM_CPU  = 4,
  parameter int unsigned IPI_BASE = 12,
  parameter int unsigned NUM_IPI  = 4,
  localparam int unsigned IW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int unsigned AW = IW + 5
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_i,
  input  logic                  we_i,
  input  logic [AW-1:0]         addr_i,
  input  logic [31:0]           wdata_i,
  output logic [31:0]           rdata_o,
  input  logic [NUM_SRC-1:0]    active_i,
  output logic [32*NUM_SRC-1:0] prio_o,
  output logic [32*NUM_SRC-1:0] dest_o,
  output logic [NUM_SRC-1:0]    reeval_o
);
  logic [IW-1:0] idx;
  reg_sel_e      sel;
  logic          hit;
  logic [31:0]   prio_a [NUM_SRC];
  logic [31:0]   dest_a [NUM_SRC];
  logic [31:0]   rd_val;
  logic [31:0]   rdata_q;

  irq_cfg_decode #(.NUM_SRC(NUM_SRC), .IW(IW), .AW(AW)) u_dec (
    .addr_i(addr_i),
    .idx_o (idx),
    .sel_o (sel),
    .hit_o (hit)
  );

  for (genvar s = 0; s < int'(NUM_SRC); s++) begin : g_src
    localparam bit IPI = (s >= int'(IPI_BASE)) && (s < int'(IPI_BASE + NUM_IPI));
    logic sel_me;
    assign sel_me = req_i && we_i && hit && (int'(idx) == s);

    irq_cfg_slot #(.NUM_CPU(NUM_CPU), .IS_IPI(IPI)) u_slot (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_prio_i(sel_me && (sel == SEL_PRIO)),
      .wr_dest_i(sel_me && (sel == SEL_DEST)),
      .wdata_i  (wdata_i),
      .active_i (active_i[s]),
      .prio_o   (prio_a[s]),
      .dest_o   (dest_a[s]),
      .reeval_o (reeval_o[s])
    );

    assign prio_o[32*s +: 32] = prio_a[s];
    assign dest_o[32*s +: 32] = dest_a[s];
  end

  always_comb begin
    rd_val = 32'hFFFF_FFFF;
    if (hit) rd_val = (sel == SEL_DEST) ? dest_a[idx] : prio_a[idx];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            rdata_q <= '0;
    else if (req_i && !we_i) rdata_q <= rd_val;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/irq_cfg_checker.sv
module irq_cfg_checker
  import irq_cfg_pkg::*;
#(
  parameter int unsigned NUM_SRC = 16,
  parameter int unsigned NUM_CPU = 4,
  parameter int unsigned AW      = 9
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  req_i,
  input logic                  we_i,
  input logic [AW-1:0]         addr_i,
  input logic [31:0]           rdata_o,
  input logic [NUM_SRC-1:0]    active_i,
  input logic [32*NUM_SRC-1:0] prio_o,
  input logic [32*NUM_SRC-1:0] dest_o,
  input logic [NUM_SRC-1:0]    reeval_o
);
  localparam logic [31:0] DKEEP = dest_keep(NUM_CPU);
  localparam logic [31:0] PLEGAL = PRIO_WMASK | PRIO_RST | (32'd1 << ACT_BIT);

  logic                  past_ok;
  logic [NUM_SRC-1:0]    act_seen;
  logic [32*NUM_SRC-1:0] prio_nact;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  for (genvar s = 0; s < int'(NUM_SRC); s++) begin : g_s
    assign act_seen[s] = prio_o[32*s + 30];
    assign prio_nact[32*s +: 32] = prio_o[32*s +: 32] & ~(32'd1 << ACT_BIT);

    assert_dest_clip_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (dest_o[32*s +: 32] & ~DKEEP) == 32'd0);
    assert_prio_fields_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (prio_o[32*s +: 32] & ~PLEGAL) == 32'd0);
  end

  assert_act_follow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> (act_seen == $past(active_i)));

  assert_misaligned_wr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && (addr_i[3:0] != 4'd0)) |=> ($stable(dest_o) && $stable(prio_nact)));

  assert_misaligned_rd_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && (addr_i[3:0] != 4'd0)) |=> (rdata_o == 32'hFFFF_FFFF));

  assert_reeval_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(reeval_o));

  assert_reeval_cause_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && (|reeval_o) |-> $past(req_i && we_i && (addr_i[4:0] == 5'd0)));
endmodule

bind irq_src_cfg_bank irq_cfg_checker #(
  .NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU), .AW(AW)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_i),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .rdata_o (rdata_o),
  .active_i(active_i),
  .prio_o  (prio_o),
  .dest_o  (dest_o),
  .reeval_o(reeval_o)
);

// File: tb/irq_src_cfg_bank_test.sv
`timescale 1ns/1ps
module irq_src_cfg_bank_test;
  localparam int NS = 8, NC = 3, IB = 6, NI = 2;
  localparam int AW = $clog2(NS) + 5;
  localparam logic [31:0] PMASK = 32'h800F_00FF;
  localparam logic [31:0] DMASK = 32'hC000_0000 | ((32'd1 << NC) - 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NS-1:0] active = '0;
  logic [32*NS-1:0] prio, dest;
  logic [NS-1:0] reeval;

  int checks = 0, errors = 0;
  logic [31:0] exp_prio [NS];
  logic [31:0] exp_dest [NS];

  always #4 clk = ~clk;

  irq_src_cfg_bank #(.NUM_SRC(NS), .NUM_CPU(NC), .IPI_BASE(IB), .NUM_IPI(NI)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .active_i(active),
    .prio_o(prio), .dest_o(dest), .reeval_o(reeval)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  function automatic logic [AW-1:0] off(input int s, input int d);
    return AW'(s * 32 + d * 16);
  endfunction

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d, output logic [NS-1:0] strobe);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    strobe = reeval;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    req = 1'b0;
    d = rdata;
  endtask

  task automatic check_bank(input string tag, input logic [NS-1:0] act);
    logic [31:0] v;
    for (int s = 0; s < NS; s++) begin
      rd(off(s, 0), v);
      chk({tag, " prio"}, v, exp_prio[s] | (act[s] ? 32'h4000_0000 : 32'h0));
      rd(off(s, 1), v);
      chk({tag, " dest"}, v, exp_dest[s]);
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [NS-1:0] st;
    logic [31:0] v, w;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 R2 R6 reset state per slot
    for (int s = 0; s < NS; s++) begin
      exp_prio[s] = 32'h8080_0000;
      exp_dest[s] = (s >= IB && s < IB + NI) ? 32'h0 : 32'h1;
    end
    check_bank("R1/R2 reset", '0);

    // R3 R9 priority writes, several patterns
    for (int p = 0; p < 3; p++) begin
      for (int s = 0; s < NS; s++) begin
        w = (p == 0) ? 32'hFFFF_FFFF : (p == 1) ? 32'h4000_0000
                                     : (32'h1357_9BDF ^ (32'h0101_0101 * s));
        wr(off(s, 0), w, st);
        exp_prio[s] = w & PMASK;
        chk("R9 prio strobe", 32'(st), 32'(1) << s);
        @(negedge clk);
        chk("R9 strobe one cycle", 32'(reeval), 32'h0);
      end
      check_bank("R3 R6 prio write", '0);
    end

    // R5 R9 destination writes
    for (int p = 0; p < 2; p++) begin
      for (int s = 0; s < NS; s++) begin
        w = (p == 0) ? 32'hFFFF_FFFF : (32'h9ABC_DEF0 + 32'(s));
        wr(off(s, 1), w, st);
        exp_dest[s] = w & DMASK;
        chk("R9 no strobe on dest", 32'(st), 32'h0);
      end
      check_bank("R5 R6 dest write", '0);
    end

    // R4 activity follows input, bus cannot touch it
    active = 8'b1010_0101;
    @(negedge clk);
    check_bank("R4 active", 8'b1010_0101);
    wr(off(0, 0), 32'h0000_0012, st);
    exp_prio[0] = 32'h0000_0012;
    rd(off(0, 0), v);
    chk("R4 write keeps act", v, 32'h4000_0012);
    wr(off(1, 0), 32'hC000_0033, st);
    exp_prio[1] = 32'h8000_0033;
    rd(off(1, 0), v);
    chk("R4 write cannot set act", v, 32'h8000_0033);
    active = '0;
    @(negedge clk);
    check_bank("R4 inactive", '0);

    // R7 R8 misaligned offsets
    for (int s = 0; s < NS; s++) begin
      for (int lo = 1; lo < 16; lo += 5) begin
        wr(off(s, 0) | AW'(lo), 32'h0F0F_0F0F, st);
        chk("R7 misaligned no strobe", 32'(st), 32'h0);
        wr(off(s, 1) | AW'(lo), 32'h0F0F_0F0F, st);
        rd(off(s, 1) | AW'(lo), v);
        chk("R8 misaligned read", v, 32'hFFFF_FFFF);
      end
    end
    check_bank("R7 bank unchanged", '0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule